// File: doc/BRIEF.md
# Dynamic 16-bit bus sizing controller

The block sits between a requester that issues 32-bit bus cycles and the external bus. A request is a dword address, four active-low byte enables, a read/write flag and write data. The block runs the physical cycle on the external bus. A physical cycle always has a start state followed by one or more further states. It ends in the first later state in which the active-low ready input is low.

In that same state the block samples an active-low width input that tells it the addressed port is only 16 bits wide. The byte enables decide what that input does. If only the low half of the bus is enabled, the width input has no effect. If only the high half is enabled, read data for the high bytes is taken from bits 15..0. If bytes 1 and 2 are both enabled, a second physical cycle follows. The second cycle carries bytes 2 and 3 on bits 15..0 and has the low byte enables negated. Writes that drive no low-half byte always copy the high data half onto the low half.

A read returns one assembled 32-bit word, with a one-cycle done pulse, once every physical cycle it needs has finished. Because the width input is sampled afresh in every cycle, 32-bit and 16-bit ports can be mixed freely.

Top module: `dyn_bus_sizer`

## Requirements
- R1: After reset, bus_cyc_o, bus_start_o, done_o and err_o are 0, bus_be_no is all ones and rdata_o is zero. Whenever bus_cyc_o is 0, bus_be_no is all ones.
- R2: Every physical cycle has bus_start_o high for exactly one state, then at least one more state with bus_cyc_o high and bus_start_o low. It ends only at a clock edge where bus_rdy_ni is low and bus_start_o is low. A low bus_rdy_ni during the start state is ignored.
- R3: When only byte enables 0 and/or 1 are asserted, exactly one physical cycle runs whatever bus_w16_ni is. Each enabled read byte i is taken from bus_rdata_i bits 8i+7..8i.
- R4: An upper-half-only read (only enables 2 and/or 3) that ends with bus_w16_ni low runs one cycle. Byte 2 is taken from bus_rdata_i[7:0] and byte 3 from bus_rdata_i[15:8].
- R5: Whenever bus_cyc_o is high and neither byte enable 0 nor 1 is asserted on bus_be_no, bus_wdata_o[15:0] equals bus_wdata_o[31:16], which carries bytes 3..2 of the request. Upper-half-only writes take one cycle at either width.
- R6: When byte enables 1 and 2 are both asserted and bus_w16_ni is low as the first cycle ends, a second cycle starts on the next state. It uses the same address and is the low half first, then the high half. The second cycle drives bus_be_no equal to the request enables with bits 1..0 forced to 1.
- R7: In the first cycle of a split write, bus_wdata_o equals the full request data. In the second cycle, bus_wdata_o[15:0] carries request bytes 3..2.
- R8: done_o pulses for one cycle, one state after the final ready, and only after all required cycles. For reads, rdata_o then holds the assembled word with every byte whose enable was negated set to zero. For writes, rdata_o is left unchanged.
- R9: When enables 1 and 2 are both asserted and bus_w16_ni is high as the cycle ends, only one cycle runs. Each enabled byte i is read from bits 8i+7..8i.
- R10: If bus_w16_ni is high when the second cycle of a split ends, err_o pulses together with done_o and the transfer completes. Read bytes of that cycle are then taken from their own positions. In all other cases err_o stays 0.
- R11: The width input is sampled per physical cycle only, so the result of each request depends solely on the width value seen at its own ready states.
- R12: req_i and the request fields are ignored while bus_cyc_o is high. The request is latched at acceptance, and bus_addr_o stays stable for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, accepted when bus_cyc_o is 0 |
| req_addr_i | input | AW | Dword address |
| req_be_ni | input | DW/8 | Byte enables, active low, contiguous |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DW | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Second cycle ended without the 16-bit indication |
| rdata_o | output | DW | Assembled read data |
| bus_cyc_o | output | 1 | Physical cycle in progress |
| bus_start_o | output | 1 | First state of a physical cycle |
| bus_addr_o | output | AW | Bus dword address |
| bus_be_no | output | DW/8 | Bus byte enables, active low |
| bus_we_o | output | 1 | Bus write flag |
| bus_wdata_o | output | DW | Bus write data |
| bus_rdata_i | input | DW | Bus read data |
| bus_rdy_ni | input | 1 | Cycle end, active low |
| bus_w16_ni | input | 1 | 16-bit port indication, active low |

## Verification
The bench targets ready asserted during the start state. A design that ends there makes one-state cycles. It sends low-half-only requests with the width input low, which a careless design would wrongly split or re-steer. Split requests check the order of the halves and that the low enables are negated in the second half. A design that sent the high half first, or left byte enables 0 and 1 on, would show wrong bus_be_no or swapped rdata_o bytes. It also checks upper-only writes for duplicated data on both widths, a second half with the width input high for the error flag, and random mixes of widths and wait states, which catch state carried over between requests.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_T1   = 2'd1,
    ST_T2   = 2'd2
  } bus_state_e;

  typedef struct packed {
    logic lo_any;
    logic span;
  } lane_use_t;
endpackage

// File: rtl/dbs_lane_use.sv
module dbs_lane_use #(
  parameter int BEW = 4
) (
  input  logic [BEW-1:0]         be_ni,
  output dbs_pkg::lane_use_t     use_o
);
  localparam int HL = BEW / 2;

  always_comb begin
    use_o.lo_any = ~&be_ni[HL-1:0];
    // bytes HL-1 and HL straddle the half boundary
    use_o.span   = ~be_ni[HL-1] & ~be_ni[HL];
  end
endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
  import dbs_pkg::*;
#(
  parameter int AW  = 30,
  parameter int BEW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [BEW-1:0] req_be_ni,
  input  logic           req_we_i,
  input  logic           rdy_ni,
  input  logic           w16_ni,
  input  logic           span_i,
  output logic           accept_o,
  output logic           capture_o,
  output logic           final_o,
  output logic           cyc_o,
  output logic           start_o,
  output logic [AW-1:0]  addr_o,
  output logic [BEW-1:0] be_no,
  output logic           we_o,
  output logic           done_o,
  output logic           err_o
);
  localparam int HL = BEW / 2;
  localparam logic [BEW-1:0] LO_MASK = {{(BEW-HL){1'b0}}, {HL{1'b1}}};

  bus_state_e     state_q;
  logic           second_q;
  logic [AW-1:0]  addr_q;
  logic [BEW-1:0] be_q;
  logic           we_q;
  logic           done_q, err_q;
  logic           go_split;

  assign cyc_o     = (state_q != ST_IDLE);
  assign start_o   = (state_q == ST_T1);
  assign accept_o  = req_i && (state_q == ST_IDLE);
  assign capture_o = (state_q == ST_T2) && !rdy_ni;
  assign go_split  = capture_o && !second_q && span_i && !w16_ni;
  assign final_o   = capture_o && !go_split;
  assign addr_o    = addr_q;
  assign we_o      = we_q;
  assign be_no     = !cyc_o ? '1 : (second_q ? (be_q | LO_MASK) : be_q);
  assign done_o    = done_q;
  assign err_o     = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      second_q <= 1'b0;
      addr_q   <= '0;
      be_q     <= '1;
      we_q     <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= final_o;
      err_q  <= final_o && second_q && w16_ni;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          addr_q   <= req_addr_i;
          be_q     <= req_be_ni;
          we_q     <= req_we_i;
          second_q <= 1'b0;
          state_q  <= ST_T1;
        end
        ST_T1: state_q <= ST_T2;
        ST_T2: if (capture_o) begin
          if (go_split) begin
            second_q <= 1'b1;
            state_q  <= ST_T1;
          end else begin
            second_q <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_t1_then_active_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (cyc_o && !start_o));

  assert_split_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && second_q) |-> $past(state_q == ST_T2 && !rdy_ni));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_err_with_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> done_q);

  assert_addr_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o && $past(cyc_o)) |-> $stable(addr_q));
endmodule

// File: rtl/dbs_steer.sv
module dbs_steer #(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic              capture_i,
  input  logic              final_i,
  input  logic              we_i,
  input  logic              lo_any_i,
  input  logic [DW/8-1:0]   bus_be_ni,
  input  logic [DW-1:0]     bus_rdata_i,
  input  logic              w16_ni,
  output logic [DW-1:0]     bus_wdata_o,
  output logic [DW-1:0]     rdata_o
);
  localparam int BEW = DW / 8;
  localparam int HL  = BEW / 2;
  localparam int HW  = DW / 2;

  logic [DW-1:0] wdat_q, acc_q, rdat_q;
  logic [DW-1:0] pick, merged;

  assign bus_wdata_o = lo_any_i ? wdat_q : {wdat_q[DW-1:HW], wdat_q[DW-1:HW]};

  for (genvar i = 0; i < BEW; i++) begin : g_lane
    localparam int SRC16 = (i % HL) * 8;
    assign pick[i*8 +: 8]   = !w16_ni ? bus_rdata_i[SRC16 +: 8] : bus_rdata_i[i*8 +: 8];
    assign merged[i*8 +: 8] = bus_be_ni[i] ? acc_q[i*8 +: 8] : pick[i*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdat_q <= '0;
      acc_q  <= '0;
      rdat_q <= '0;
    end else begin
      if (accept_i) begin
        wdat_q <= req_wdata_i;
        acc_q  <= '0;
      end else if (capture_i) begin
        acc_q <= merged;
      end
      if (final_i && !we_i) rdat_q <= merged;
    end
  end

  assign rdata_o = rdat_q;

  assert_rdata_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(final_i) |-> $stable(rdat_q));
endmodule

// File: rtl/dyn_bus_sizer.sv
module dyn_bus_sizer #(
  parameter int AW = 30,
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW/8-1:0]   req_be_ni,
  input  logic              req_we_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [DW-1:0]     rdata_o,
  output logic              bus_cyc_o,
  output logic              bus_start_o,
  output logic [AW-1:0]     bus_addr_o,
  output logic [DW/8-1:0]   bus_be_no,
  output logic              bus_we_o,
  output logic [DW-1:0]     bus_wdata_o,
  input  logic [DW-1:0]     bus_rdata_i,
  input  logic              bus_rdy_ni,
  input  logic              bus_w16_ni
);
  localparam int BEW = DW / 8;

  dbs_pkg::lane_use_t cur_use;
  logic accept, capture, fin;

  dbs_seq #(.AW(AW), .BEW(BEW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .req_addr_i (req_addr_i),
    .req_be_ni  (req_be_ni),
    .req_we_i   (req_we_i),
    .rdy_ni     (bus_rdy_ni),
    .w16_ni     (bus_w16_ni),
    .span_i     (cur_use.span),
    .accept_o   (accept),
    .capture_o  (capture),
    .final_o    (fin),
    .cyc_o      (bus_cyc_o),
    .start_o    (bus_start_o),
    .addr_o     (bus_addr_o),
    .be_no      (bus_be_no),
    .we_o       (bus_we_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  dbs_lane_use #(.BEW(BEW)) u_use (
    .be_ni (bus_be_no),
    .use_o (cur_use)
  );

  dbs_steer #(.DW(DW)) u_steer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .req_wdata_i (req_wdata_i),
    .capture_i   (capture),
    .final_i     (fin),
    .we_i        (bus_we_o),
    .lo_any_i    (cur_use.lo_any),
    .bus_be_ni   (bus_be_no),
    .bus_rdata_i (bus_rdata_i),
    .w16_ni      (bus_w16_ni),
    .bus_wdata_o (bus_wdata_o),
    .rdata_o     (rdata_o)
  );

  assert_idle_be_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_cyc_o |-> (bus_be_no == '1));

  assert_upper_dup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && (&bus_be_no[BEW/2-1:0])) |-> (bus_wdata_o[DW/2-1:0] == bus_wdata_o[DW-1:DW/2]));
endmodule

// File: tb/dyn_bus_sizer_test.sv
module dyn_bus_sizer_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [29:0] req_addr_i = '0;
  logic [3:0]  req_be_ni = 4'hf;
  logic        req_we_i = 1'b0;
  logic [31:0] req_wdata_i = '0;
  logic        done_o, err_o, bus_cyc_o, bus_start_o, bus_we_o;
  logic [31:0] rdata_o, bus_wdata_o;
  logic [29:0] bus_addr_o;
  logic [3:0]  bus_be_no;
  logic [31:0] bus_rdata_i = '0;
  logic        bus_rdy_ni = 1'b1;
  logic        bus_w16_ni = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dyn_bus_sizer uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_addr_i(req_addr_i),
    .req_be_ni(req_be_ni), .req_we_i(req_we_i), .req_wdata_i(req_wdata_i),
    .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o), .bus_cyc_o(bus_cyc_o),
    .bus_start_o(bus_start_o), .bus_addr_o(bus_addr_o), .bus_be_no(bus_be_no),
    .bus_we_o(bus_we_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
    .bus_rdy_ni(bus_rdy_ni), .bus_w16_ni(bus_w16_ni)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_wdata(input logic [3:0] be, input logic [31:0] wd);
    return (be[1:0] == 2'b00) ? {wd[31:16], wd[31:16]} : wd;
  endfunction

  function automatic logic [31:0] merge_rd(input logic [31:0] acc, input logic [3:0] be,
                                           input logic is16, input logic [31:0] rd);
    logic [31:0] r = acc;
    for (int i = 0; i < 4; i++)
      if (be[i]) r[i*8 +: 8] = is16 ? rd[(i%2)*8 +: 8] : rd[i*8 +: 8];
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] be, input logic is16, input logic we);
    if (be[3:2] == 2'b00) return "R3";
    if (be[1:0] == 2'b00) return we ? "R5" : "R4";
    if (be[1] && be[2]) return is16 ? (we ? "R7" : "R8") : "R9";
    return "R11";
  endfunction

  // be is active high here; bus_be_no is its inverse
  task automatic run_txn(input logic [29:0] a, input logic [3:0] be, input logic we,
                         input logic [31:0] wd, input logic is16_a, input logic is16_b,
                         input int wt_a, input int wt_b, input logic [31:0] rd_a,
                         input logic [31:0] rd_b, input logic t1_rdy);
    logic split;
    int nph;
    logic [31:0] exp_rd;
    logic [31:0] old_rd;
    logic [3:0] pb;
    logic is16;
    int wt;
    string tg;
    split = be[1] & be[2] & is16_a;
    nph = split ? 2 : 1;
    exp_rd = '0;
    tg = tag_of(be, is16_a, we);
    @(negedge clk);
    old_rd = rdata_o;
    req_i = 1'b1; req_addr_i = a; req_be_ni = ~be; req_we_i = we; req_wdata_i = wd;
    @(negedge clk);
    for (int p = 0; p < nph; p++) begin
      pb   = (p == 1) ? (be & 4'b1100) : be;
      is16 = (p == 1) ? is16_b : is16_a;
      wt   = (p == 1) ? wt_b : wt_a;
      chk(bus_cyc_o && bus_start_o, "R2", {30'd0, bus_cyc_o, bus_start_o}, 32'h3);
      chk(bus_addr_o == a, "R12", {2'b0, bus_addr_o}, {2'b0, a});
      chk(bus_be_no == ~pb, (p == 1) ? "R6" : tg, {28'd0, bus_be_no}, {28'd0, ~pb});
      if (we) chk(bus_wdata_o == exp_wdata(pb, wd), (p == 1) ? "R7" : "R5", bus_wdata_o, exp_wdata(pb, wd));
      if (p == 0) begin
        // busy: a new request must be ignored
        req_addr_i = ~a; req_wdata_i = ~wd; req_be_ni = 4'h0; req_we_i = ~we;
      end
      bus_rdy_ni  = t1_rdy ? 1'b0 : 1'b1;
      bus_w16_ni  = 1'($urandom);
      bus_rdata_i = $urandom;
      for (int w = 0; w <= wt; w++) begin
        @(negedge clk);
        if (p == 0 && w == 0) req_i = 1'b0;
        chk(bus_cyc_o && !bus_start_o && !done_o, "R2", {29'd0, bus_cyc_o, bus_start_o, done_o}, 32'h4);
        if (w < wt) begin
          bus_rdy_ni = 1'b1;
          bus_w16_ni = 1'($urandom);
        end else begin
          bus_rdy_ni  = 1'b0;
          bus_w16_ni  = ~is16;
          bus_rdata_i = (p == 1) ? rd_b : rd_a;
        end
      end
      exp_rd = merge_rd(exp_rd, pb, is16, (p == 1) ? rd_b : rd_a);
      @(negedge clk);
      bus_rdy_ni = 1'b1;
      bus_w16_ni = 1'($urandom);
      bus_rdata_i = $urandom;
    end
    chk(done_o == 1'b1, "R8", {31'd0, done_o}, 32'd1);
    chk(err_o == (split && !is16_b), "R10", {31'd0, err_o}, {31'd0, split && !is16_b});
    if (!we) chk(rdata_o == exp_rd, tg, rdata_o, exp_rd);
    else     chk(rdata_o == old_rd, "R8", rdata_o, old_rd);
    chk(!bus_cyc_o && bus_be_no == 4'hf, "R12", {27'd0, bus_cyc_o, bus_be_no}, 32'hf);
    @(negedge clk);
    chk(!done_o && !err_o && !bus_cyc_o, "R8", {30'd0, done_o, err_o}, 32'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0b16));
    repeat (3) @(negedge clk);
    chk(!bus_cyc_o && !bus_start_o && !done_o && !err_o, "R1",
        {28'd0, bus_cyc_o, bus_start_o, done_o, err_o}, 32'd0);
    chk(bus_be_no == 4'hf && rdata_o == 32'd0, "R1", {28'd0, bus_be_no}, 32'hf);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!bus_cyc_o && bus_be_no == 4'hf, "R1", {27'd0, bus_cyc_o, bus_be_no}, 32'hf);

    // R3 low half only, 16-bit asserted: no split, own lanes
    run_txn(30'h1234, 4'b0011, 1'b0, 32'h0, 1'b1, 1'b1, 0, 0, 32'hA1B2C3D4, 32'h0, 1'b0);
    // R4 upper only read on 16-bit port
    run_txn(30'h0042, 4'b1100, 1'b0, 32'h0, 1'b1, 1'b1, 2, 0, 32'h55667788, 32'h0, 1'b1);
    // R5 upper only writes, both widths
    run_txn(30'h0043, 4'b1000, 1'b1, 32'hDEADBEEF, 1'b0, 1'b0, 1, 0, 32'h0, 32'h0, 1'b0);
    run_txn(30'h0044, 4'b1100, 1'b1, 32'hCAFEF00D, 1'b1, 1'b0, 0, 0, 32'h0, 32'h0, 1'b0);
    // R6 R7 split write
    run_txn(30'h3FFF, 4'b1111, 1'b1, 32'h01234567, 1'b1, 1'b1, 1, 2, 32'h0, 32'h0, 1'b1);
    // R6 R8 split read, partial enables
    run_txn(30'h0100, 4'b0110, 1'b0, 32'h0, 1'b1, 1'b1, 0, 1, 32'h1111AA22, 32'h3333BB44, 1'b0);
    // R9 span on 32-bit port
    run_txn(30'h0101, 4'b1111, 1'b0, 32'h0, 1'b0, 1'b0, 0, 0, 32'h89ABCDEF, 32'h0, 1'b0);
    // R10 second half without 16-bit indication
    run_txn(30'h0102, 4'b1110, 1'b0, 32'h0, 1'b1, 1'b0, 0, 0, 32'h00007766, 32'h99880000, 1'b1);

    // R11 random mix of widths, enables and waits
    for (int k = 0; k < 300; k++) begin
      int st;
      int ln;
      logic [3:0] be;
      st = $urandom % 4;
      ln = 1 + ($urandom % (4 - st));
      be = 4'(((1 << ln) - 1) << st);
      run_txn(30'($urandom), be, 1'($urandom), $urandom, 1'($urandom), 1'($urandom % 4 != 0),
              $urandom % 4, $urandom % 4, $urandom, $urandom, 1'($urandom));
    end
    finish_run();
  end
endmodule